// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns the contents of four 5-bit bank-control registers into physical addresses for a cartridge's program ROM, character memory and program RAM. It also produces the nametable select bit that sets the screen mirroring. Every CPU-side and picture-side access passes through it. The CPU address picks a 16 KB window, and the mode bits decide whether that window follows the program bank register or stays pinned to a fixed bank. The picture address picks a 4 KB half, which is served either by two independent 4 KB banks or by one 8 KB pair.

Two configuration inputs cover larger boards. When `big_prg` is set, bit 4 of the active character bank register becomes program address bit 18, which selects a 256 KB outer half. When `ram32k` is set, bits 3:2 of that same register choose one of four 8 KB RAM banks. The block does not load the registers and does not contain the memories. With `OUT_REG=1`, which is the default, every output is registered once.

Top module: `cart_bank_xlate`

## Requirements
- R1: The nametable bit follows `ctrl_reg[1:0]`. Value 0 gives constant 0, value 1 gives constant 1, value 2 gives `ppu_addr[10]`, and value 3 gives `ppu_addr[11]`.
- R2: When `ctrl_reg[3]` is 0 (32 KB program mode), `prg_rom_addr[17:14]` equals `{prg_reg[3:1], cpu_addr[14]}`, and `prg_reg[0]` has no effect.
- R3: When `ctrl_reg[3:2]` is 2'b11, the 0x8000 window uses `prg_reg[3:0]` and the 0xC000 window uses bank 15.
- R4: When `ctrl_reg[3:2]` is 2'b10, the 0x8000 window uses bank 0 and the 0xC000 window uses `prg_reg[3:0]`.
- R5: When `ctrl_reg[4]` is 0, `chr_addr[16:12]` equals `{chr0_reg[4:1], ppu_addr[12]}`, and `chr1_reg` has no effect.
- R6: When `ctrl_reg[4]` is 1, `chr_addr[16:12]` is `chr0_reg` for `ppu_addr[12]`=0 and `chr1_reg` for `ppu_addr[12]`=1.
- R7: The chosen character register is `chr1_reg` when `chr1_last` and `ctrl_reg[4]` are both 1, and `chr0_reg` otherwise. `prg_rom_addr[18]` is bit 4 of the chosen register when `big_prg` is 1, and 0 when `big_prg` is 0.
- R8: `prg_ram_en` is 1 exactly when `cpu_addr[15:13]` is 3'b011 and either `prg_reg[4]` is 0 or `ram_force_on` is 1.
- R9: `prg_ram_bank` is bits 3:2 of the chosen character register when `ram32k` is 1, and 0 otherwise.
- R10: `prg_rom_en` equals `cpu_addr[15]`. The low 14 bits of `prg_rom_addr` and the low 12 bits of `chr_addr` pass the access offset through unchanged.
- R11: Outputs are zero during reset. After reset, each output reflects the inputs of the previous clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 14 | Picture bus address |
| ctrl_reg | input | 5 | Mode register: mirroring, program mode, character mode |
| chr0_reg | input | 5 | Character bank register 0 |
| chr1_reg | input | 5 | Character bank register 1 |
| prg_reg | input | 5 | Program bank register; bit 4 disables RAM |
| chr1_last | input | 1 | Register 1 was the last character register written |
| big_prg | input | 1 | 512 KB program configuration |
| ram32k | input | 1 | 32 KB RAM configuration |
| ram_force_on | input | 1 | RAM stays enabled whatever `prg_reg[4]` holds |
| prg_rom_addr | output | 19 | Physical program ROM address |
| prg_rom_en | output | 1 | Program ROM select |
| chr_addr | output | 17 | Physical character memory address |
| prg_ram_en | output | 1 | Program RAM select |
| prg_ram_bank | output | 2 | 8 KB RAM bank |
| nt_bank | output | 1 | Nametable select bit |

## Verification
The hardest case to reach is the outer-bank source switching to `chr1_reg`. That needs `big_prg`, `chr1_last` and `ctrl_reg[4]` all set at once, and random stimulus alone rarely lines them up. The bench therefore runs directed cases over all eight combinations of those three bits, with the two character registers holding opposite values in bits 4:2. The same cases cover the RAM bank choice, and they sit alongside random traffic in every program window and mirroring mode.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  localparam int CPU_AW  = 16;
  localparam int PPU_AW  = 14;
  localparam int REG_W   = 5;
  localparam int PBANK_W = 4;
  localparam int PRG_OFF = 14;
  localparam int CHR_OFF = 12;
  localparam int PRG_AW  = 1 + PBANK_W + PRG_OFF;
  localparam int CHR_AW  = REG_W + CHR_OFF;
  localparam int RBANK_W = 2;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORIZ  = 2'd3
  } mirror_e;

  typedef struct packed {
    logic [PRG_AW-1:0]  rom_addr;
    logic               rom_en;
    logic [CHR_AW-1:0]  chr_addr;
    logic               ram_en;
    logic [RBANK_W-1:0] ram_bank;
    logic               nt;
  } xlate_t;
endpackage

// File: rtl/cbx_prg_map.sv
module cbx_prg_map
  import cbx_pkg::*;
(
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [3:2]        mode,
  input  logic [REG_W-1:0]  prg_reg,
  input  logic              outer_bit,
  output logic [PRG_AW-1:0] rom_addr,
  output logic              rom_en
);
  localparam logic [PBANK_W-1:0] LAST_BANK = '1;
  logic             hi_win;
  logic [PBANK_W-1:0] bank;

  always_comb begin
    hi_win = cpu_addr[PRG_OFF];
    if (!mode[3]) begin
      bank = {prg_reg[PBANK_W-1:1], hi_win};
    end else if (mode[2]) begin
      bank = hi_win ? LAST_BANK : prg_reg[PBANK_W-1:0];
    end else begin
      bank = hi_win ? prg_reg[PBANK_W-1:0] : '0;
    end
    rom_addr = {outer_bit, bank, cpu_addr[PRG_OFF-1:0]};
    rom_en   = cpu_addr[CPU_AW-1];
  end
endmodule

// File: rtl/cbx_chr_map.sv
module cbx_chr_map
  import cbx_pkg::*;
(
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              split4k,
  input  logic [REG_W-1:0]  chr0_reg,
  input  logic [REG_W-1:0]  chr1_reg,
  input  logic [1:0]        mir,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              nt
);
  logic [REG_W-1:0] page;
  logic             half;

  always_comb begin
    half = ppu_addr[CHR_OFF];
    if (split4k) page = half ? chr1_reg : chr0_reg;
    else         page = {chr0_reg[REG_W-1:1], half};
    chr_addr = {page, ppu_addr[CHR_OFF-1:0]};
    unique case (mirror_e'(mir))
      MIR_ONE_LO: nt = 1'b0;
      MIR_ONE_HI: nt = 1'b1;
      MIR_VERT:   nt = ppu_addr[10];
      MIR_HORIZ:  nt = ppu_addr[11];
      default:    nt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbx_ram_map.sv
module cbx_ram_map
  import cbx_pkg::*;
(
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               ram_off,
  input  logic               force_on,
  input  logic               ram32k,
  input  logic [REG_W-1:0]   sel_chr,
  output logic               ram_en,
  output logic [RBANK_W-1:0] ram_bank
);
  always_comb begin
    ram_en   = (cpu_addr[CPU_AW-1:13] == 3'b011) && (!ram_off || force_on);
    ram_bank = ram32k ? sel_chr[3:2] : '0;
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cbx_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_AW-1:0]   cpu_addr,
  input  logic [PPU_AW-1:0]   ppu_addr,
  input  logic [REG_W-1:0]    ctrl_reg,
  input  logic [REG_W-1:0]    chr0_reg,
  input  logic [REG_W-1:0]    chr1_reg,
  input  logic [REG_W-1:0]    prg_reg,
  input  logic                chr1_last,
  input  logic                big_prg,
  input  logic                ram32k,
  input  logic                ram_force_on,
  output logic [PRG_AW-1:0]   prg_rom_addr,
  output logic                prg_rom_en,
  output logic [CHR_AW-1:0]   chr_addr,
  output logic                prg_ram_en,
  output logic [RBANK_W-1:0]  prg_ram_bank,
  output logic                nt_bank
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // the character register that feeds the outer bank and RAM bank
  logic [REG_W-1:0] sel_chr;
  logic             outer_bit;
  always_comb begin
    sel_chr   = (chr1_last && ctrl_reg[4]) ? chr1_reg : chr0_reg;
    outer_bit = big_prg & sel_chr[4];
  end

  xlate_t nx;

  cbx_prg_map u_prg (
    .cpu_addr  (cpu_addr),
    .mode      (ctrl_reg[3:2]),
    .prg_reg   (prg_reg),
    .outer_bit (outer_bit),
    .rom_addr  (nx.rom_addr),
    .rom_en    (nx.rom_en)
  );

  cbx_chr_map u_chr (
    .ppu_addr (ppu_addr),
    .split4k  (ctrl_reg[4]),
    .chr0_reg (chr0_reg),
    .chr1_reg (chr1_reg),
    .mir      (ctrl_reg[1:0]),
    .chr_addr (nx.chr_addr),
    .nt       (nx.nt)
  );

  cbx_ram_map u_ram (
    .cpu_addr (cpu_addr),
    .ram_off  (prg_reg[4]),
    .force_on (ram_force_on),
    .ram32k   (ram32k),
    .sel_chr  (sel_chr),
    .ram_en   (nx.ram_en),
    .ram_bank (nx.ram_bank)
  );

  xlate_t q;

  generate
    if (OUT_REG) begin : g_reg
      logic out_ce;
      logic loaded;
      assign out_ce = 1'b1;

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)  q <= '0;
        else if (out_ce)  q <= nx;
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) loaded <= 1'b0;
        else             loaded <= 1'b1;
      end

      AST_ROM_EN_LAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
        loaded |-> prg_rom_en == $past(cpu_addr[CPU_AW-1])); // R10
      AST_RAM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (loaded && $past(prg_reg[4] && !ram_force_on)) |-> !prg_ram_en); // R8
      AST_NT_CONST_HI: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (loaded && $past(ctrl_reg[1:0] == 2'd1)) |-> nt_bank); // R1
      AST_HI_WIN_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (loaded && $past(ctrl_reg[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11))
          |-> prg_rom_addr[17:14] == 4'hF); // R3
      AST_CHR_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (loaded && $past(!ctrl_reg[4])) |-> chr_addr[12] == $past(ppu_addr[12])); // R5
    end else begin : g_comb
      assign q = nx;
    end
  endgenerate

  assign prg_rom_addr = q.rom_addr;
  assign prg_rom_en   = q.rom_en;
  assign chr_addr     = q.chr_addr;
  assign prg_ram_en   = q.ram_en;
  assign prg_ram_bank = q.ram_bank;
  assign nt_bank      = q.nt;
endmodule

// File: tb/sim_cart_bank_xlate.sv
module sim_cart_bank_xlate;
  localparam time TCLK = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [13:0] ppu_addr;
  logic [4:0]  ctrl_reg, chr0_reg, chr1_reg, prg_reg;
  logic        chr1_last, big_prg, ram32k, ram_force_on;
  logic [18:0] prg_rom_addr;
  logic        prg_rom_en;
  logic [16:0] chr_addr;
  logic        prg_ram_en;
  logic [1:0]  prg_ram_bank;
  logic        nt_bank;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  cart_bank_xlate u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] pick_chr();
    return (chr1_last && ctrl_reg[4]) ? chr1_reg : chr0_reg;
  endfunction

  function automatic logic [18:0] exp_rom();
    logic [3:0] b;
    logic       o;
    o = big_prg ? pick_chr() >> 4 : 1'b0;
    if (!ctrl_reg[3])     b = {prg_reg[3:1], cpu_addr[14]};
    else if (ctrl_reg[2]) b = cpu_addr[14] ? 4'd15 : prg_reg[3:0];
    else                  b = cpu_addr[14] ? prg_reg[3:0] : 4'd0;
    return {o, b, cpu_addr[13:0]};
  endfunction

  function automatic logic [16:0] exp_chr();
    logic [4:0] p;
    if (ctrl_reg[4]) p = ppu_addr[12] ? chr1_reg : chr0_reg;
    else             p = {chr0_reg[4:1], ppu_addr[12]};
    return {p, ppu_addr[11:0]};
  endfunction

  function automatic logic exp_nt();
    case (ctrl_reg[1:0])
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return ppu_addr[10];
      default: return ppu_addr[11];
    endcase
  endfunction

  // drive at negedge, let one posedge load, sample at the next negedge
  task automatic apply_and_check();
    logic [18:0] er;
    logic [16:0] ec;
    logic        en, rme;
    logic [1:0]  rb;
    er  = exp_rom();
    ec  = exp_chr();
    en  = exp_nt();
    rme = (cpu_addr[15:13] == 3'b011) && (!prg_reg[4] || ram_force_on);
    rb  = ram32k ? pick_chr() >> 2 : 2'd0;
    @(negedge clk);
    chk(ctrl_reg[3] ? (ctrl_reg[2] ? "R3 rom" : "R4 rom") : "R2 rom", 32'(prg_rom_addr[17:0]), 32'(er[17:0]));
    chk("R7 outer", 32'(prg_rom_addr[18]), 32'(er[18]));
    chk("R10 rom_en", 32'(prg_rom_en), 32'(cpu_addr[15]));
    chk(ctrl_reg[4] ? "R6 chr" : "R5 chr", 32'(chr_addr), 32'(ec));
    chk("R1 nt", 32'(nt_bank), 32'(en));
    chk("R8 ram_en", 32'(prg_ram_en), 32'(rme));
    chk("R9 ram_bank", 32'(prg_ram_bank), 32'(rb));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cpu_addr = 16'hFFFF; ppu_addr = 14'h3FFF;
    ctrl_reg = '1; chr0_reg = '1; chr1_reg = '1; prg_reg = 5'h0F;
    chr1_last = 1'b1; big_prg = 1'b1; ram32k = 1'b1; ram_force_on = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs stay zero while reset is held
    chk("R11 reset rom", 32'(prg_rom_addr), 0);
    chk("R11 reset chr", 32'(chr_addr), 0);
    chk("R11 reset flags", 32'({prg_rom_en, prg_ram_en, prg_ram_bank, nt_bank}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: one cycle of latency
    cpu_addr = 16'h8123; ctrl_reg = 5'h0C; prg_reg = 5'h05; big_prg = 1'b0;
    @(posedge clk); #1;
    cpu_addr = 16'h0000;
    @(negedge clk);
    chk("R11 latency", 32'(prg_rom_addr), 32'({1'b0, 4'd5, 14'h0123}));
    @(negedge clk);
    chk("R11 follows", 32'(prg_rom_en), 0);

    // R1: each mirroring mode
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 4; a++) begin
        ctrl_reg = 5'(m); ppu_addr = 14'(a << 10);
        apply_and_check();
      end
    end

    // R2 R3 R4: every program mode in both windows, prg bit 0 toggled
    for (int md = 0; md < 4; md++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 2; p++) begin
          ctrl_reg = 5'(md << 2); prg_reg = 5'(4'hA | p);
          cpu_addr = 16'h8000 | 16'(w << 14) | 16'h0ABC;
          big_prg = 1'b0;
          apply_and_check();
        end
      end
    end

    // R7 R9: outer and RAM bank source over all selector combinations
    chr0_reg = 5'b00100; chr1_reg = 5'b11000;
    for (int s = 0; s < 8; s++) begin
      big_prg = s[0]; chr1_last = s[1]; ctrl_reg = s[2] ? 5'h10 : 5'h00;
      ram32k = 1'b1; cpu_addr = 16'h6000; prg_reg = 5'h00; ram_force_on = 1'b0;
      apply_and_check();
      cpu_addr = 16'hC000;
      apply_and_check();
    end

    // R8: RAM disable and force
    for (int s = 0; s < 4; s++) begin
      prg_reg = s[0] ? 5'h10 : 5'h00; ram_force_on = s[1];
      cpu_addr = 16'h7FFF;
      apply_and_check();
      cpu_addr = 16'h5FFF;
      apply_and_check();
    end

    // R5 R6: character modes with chr1 varying
    for (int s = 0; s < 4; s++) begin
      ctrl_reg = s[0] ? 5'h10 : 5'h00; ppu_addr = s[1] ? 14'h1555 : 14'h0AAA;
      chr0_reg = 5'h13; chr1_reg = 5'h0C;
      apply_and_check();
      chr1_reg = 5'h1F;
      apply_and_check();
    end

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cpu_addr = 16'($urandom); ppu_addr = 14'($urandom);
      ctrl_reg = 5'($urandom); chr0_reg = 5'($urandom);
      chr1_reg = 5'($urandom); prg_reg = 5'($urandom);
      {chr1_last, big_prg, ram32k, ram_force_on} = 4'($urandom);
      apply_and_check();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule